// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog counter that runs on a slow free-running clock and guards a processor against runaway code. Software reaches it from the bus clock domain through a small register write port and a combinational read port. The control register holds a 5-bit enable key and a 3-bit period select. Only two key values are accepted: one turns the counter on and one turns it off. Any other key value is treated as a fault. It produces a delayed full device reset and sets a sticky software-reset flag.

When the counter reaches the end of its period, the response depends on the power mode. In run mode the block issues a full device reset. In sleep/idle mode it issues only a partial reset, which restarts the program counter and stack pointer. In both modes it sets a time-out flag. A clear strobe from the bus side restarts the count and clears the time-out flag.

Register writes and clear strobes cross into the slow domain through a toggle request/acknowledge handshake. Register read-back returns to the bus domain through synchronizers. Sleep mode is synchronized into the slow domain.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset the key field is 01010b and the period select is 7. Control reads (address 0) return 0xEA, status reads (address 1) return 0x00, and no reset output is active.
- R2: While the key field holds 10101b the count stays at zero, and neither reset output is produced by a time-out.
- R3: While the key field holds 01010b the counter advances once per slow clock and overflows when it reaches its period.
- R4: Writing any key other than 01010b or 10101b produces a device reset pulse 2 slow cycles after the key is taken. The same pulse sets the software-reset flag, and the key and period return to their power-on values.
- R5: The software-reset flag (status bit 0) survives the reset it causes. It is cleared only by writing status with bit 0 = 0; writing bit 0 = 1 has no effect.
- R6: An overflow in run mode pulses `dev_rst`, sets the time-out flag (status bit 1), restores the power-on control value, and does not pulse `pcsp_rst`.
- R7: An overflow in sleep mode pulses `pcsp_rst` and sets the time-out flag, without `dev_rst`.
- R8: A clear strobe zeroes the count and clears the time-out flag. Strobes repeated faster than the period prevent any overflow.
- R9: Control bits [7:5] pick an overflow period of 2^(8+sel) slow cycles. Control bits [4:0] hold the key.
- R10: Each reset output is a single slow-cycle pulse, and the two are never active together.
- R11: Control reads return the last accepted value. Status bits [7:2] read as 0.
- R12: `wr_busy` is high while a write is in flight, and a write offered while it is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow watchdog clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe (bus domain) |
| wr_addr | input | 1 | 0 = control, 1 = status |
| wr_data | input | 8 | Write data |
| wr_busy | output | 1 | Write handshake in progress |
| rd_addr | input | 1 | Read select, same map as writes |
| rd_data | output | 8 | Read data |
| wdt_clr | input | 1 | Clear-watchdog strobe (bus domain) |
| sleep_mode | input | 1 | Sleep/idle mode, asynchronous |
| dev_rst | output | 1 | Full device reset pulse (slow domain) |
| pcsp_rst | output | 1 | Program-counter/stack-pointer reset pulse (slow domain) |
| to_flag | output | 1 | Time-out flag |
| wrf_flag | output | 1 | Software-reset flag |

## Verification
The assertions check the following on every cycle:
- both reset outputs are single-cycle pulses and are never active together;
- a disabled key forces the count to zero;
- a partial reset comes only from sleep mode with the time-out flag set;
- the software-reset flag rises only together with a device reset that restores the power-on key, and falls only after a status write with bit 0 clear;
- held write data stays stable while the handshake is busy.

Only the bench scenarios can show the exact overflow period for each period select, that repeated clears hold off time-outs, and that a write offered while busy leaves the control register unchanged. They also show that the software-reset flag survives its own reset, and the full sequence from a run-mode time-out through to read-back of the restored control value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int REG_W = 8;
   localparam int KEY_W = 5;
   localparam int SEL_W = REG_W - KEY_W;

   localparam logic [KEY_W-1:0] KEY_RUN = 5'b01010;
   localparam logic [KEY_W-1:0] KEY_OFF = 5'b10101;
   localparam logic [REG_W-1:0] CTRL_RST = {{SEL_W{1'b1}}, KEY_RUN};

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   typedef enum logic [1:0] {
      KS_RUN,
      KS_OFF,
      KS_BAD
   } key_state_e;

   typedef struct packed {
      logic             addr;
      logic [REG_W-1:0] data;
   } wr_req_t;

   function automatic key_state_e key_decode(input logic [KEY_W-1:0] k);
      if (k == KEY_RUN)      return KS_RUN;
      else if (k == KEY_OFF) return KS_OFF;
      else                   return KS_BAD;
   endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wdt_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("wdt_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES+1];
   assign chain[0] = d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g+1] <= RST_VAL;
         else        chain[g+1] <= chain[g];
      end
   end

   assign q = chain[STAGES];

endmodule

// File: rtl/wdt_xfer.sv
module wdt_xfer #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic         src_launch,
   input  logic [W-1:0] src_data,
   output logic         src_busy,
   output logic         dst_pulse,
   output logic [W-1:0] dst_data
);

   logic         req_t;
   logic         req_d;
   logic         req_seen;
   logic         ack_s;
   logic [W-1:0] hold_q;

   // source side: toggle a request and hold the payload until acknowledged
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_t  <= 1'b0;
         hold_q <= '0;
      end else if (src_launch && !src_busy) begin
         req_t  <= ~req_t;
         hold_q <= src_data;
      end
   end

   assign src_busy = req_t ^ ack_s;

   wdt_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk   (dst_clk),
      .rst_n (rst_n),
      .d     (req_t),
      .q     (req_d)
   );

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) req_seen <= 1'b0;
      else        req_seen <= req_d;
   end

   assign dst_pulse = req_d ^ req_seen;
   assign dst_data  = hold_q;

   wdt_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (req_seen),
      .q     (ack_s)
   );

   // R12: payload seen by the slow side never moves while in flight
   p_hold_stable_r12: assert property (@(posedge src_clk) disable iff (!rst_n)
      (src_busy && $past(src_busy)) |-> $stable(hold_q));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int MIN_LOG2  = 8,
   parameter int ILL_DELAY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_pulse,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic             clr_pulse,
   input  logic             sleep,
   output logic             dev_rst,
   output logic             pcsp_rst,
   output logic             to_flag,
   output logic             wrf_flag,
   output logic [REG_W-1:0] ctrl_rd,
   output logic [REG_W-1:0] stat_rd
);

   localparam int CNT_W = MIN_LOG2 + (1 << SEL_W) - 1;
   localparam int DLY_W = $clog2(ILL_DELAY + 1);

   if (MIN_LOG2 < 2) begin : g_bad_log2
      $error("wdt_core: MIN_LOG2 must be at least 2");
   end
   if (ILL_DELAY < 1) begin : g_bad_delay
      $error("wdt_core: ILL_DELAY must be at least 1");
   end

   logic [KEY_W-1:0] key_q;
   logic [SEL_W-1:0] per_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [DLY_W-1:0] ill_cnt_q;
   logic             to_q;
   logic             wrf_q;
   logic             dev_rst_q;
   logic             pcsp_rst_q;

   key_state_e ks;
   logic       ill_fire;
   logic       ovf;
   logic       wr_ctrl;
   logic       wr_stat;
   logic       wr_is_off;

   assign ks = key_decode(key_q);

   // terminal count: 2^(MIN_LOG2+sel) - 1
   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         lim[i] = (i < (MIN_LOG2 + int'(per_q)));
      end
   end

   assign ill_fire  = (ks == KS_BAD) && (ill_cnt_q == DLY_W'(ILL_DELAY - 1));
   assign ovf       = (ks == KS_RUN) && (cnt_q >= lim);
   assign wr_ctrl   = wr_pulse && (wr_addr == ADDR_CTRL);
   assign wr_stat   = wr_pulse && (wr_addr == ADDR_STAT);
   assign wr_is_off = (key_decode(wr_data[KEY_W-1:0]) == KS_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q      <= KEY_RUN;
         per_q      <= '1;
         cnt_q      <= '0;
         ill_cnt_q  <= '0;
         to_q       <= 1'b0;
         wrf_q      <= 1'b0;
         dev_rst_q  <= 1'b0;
         pcsp_rst_q <= 1'b0;
      end else begin
         dev_rst_q  <= 1'b0;
         pcsp_rst_q <= 1'b0;
         if (ill_fire) begin
            key_q     <= KEY_RUN;
            per_q     <= '1;
            cnt_q     <= '0;
            ill_cnt_q <= '0;
            wrf_q     <= 1'b1;
            dev_rst_q <= 1'b1;
         end else begin
            ill_cnt_q <= (ks == KS_BAD) ? ill_cnt_q + DLY_W'(1) : '0;
            if (wr_ctrl) begin
               key_q <= wr_data[KEY_W-1:0];
               per_q <= wr_data[REG_W-1:KEY_W];
            end
            if (wr_stat && !wr_data[0]) wrf_q <= 1'b0;
            if (clr_pulse) begin
               cnt_q <= '0;
               to_q  <= 1'b0;
            end else if (ovf) begin
               cnt_q <= '0;
               to_q  <= 1'b1;
               if (sleep) begin
                  pcsp_rst_q <= 1'b1;
               end else begin
                  dev_rst_q <= 1'b1;
                  key_q     <= KEY_RUN;
                  per_q     <= '1;
               end
            end else if (ks == KS_RUN) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
            if (wr_ctrl && wr_is_off) cnt_q <= '0;
         end
      end
   end

   assign dev_rst  = dev_rst_q;
   assign pcsp_rst = pcsp_rst_q;
   assign to_flag  = to_q;
   assign wrf_flag = wrf_q;
   assign ctrl_rd  = {per_q, key_q};
   assign stat_rd  = {{(REG_W-2){1'b0}}, to_q, wrf_q};

   // R10: reset outputs are single-cycle and mutually exclusive
   p_dev_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_q |=> !dev_rst_q);
   p_pcsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pcsp_rst_q |=> !pcsp_rst_q);
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rst_q && pcsp_rst_q));
   // R2: a disabled key holds the count at zero and yields no time-out
   p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_q == KEY_OFF) |-> (cnt_q == '0));
   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_q == KEY_OFF) |=> !pcsp_rst_q);
   // R7: partial reset only in sleep mode, with the time-out flag set
   p_pcsp_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pcsp_rst_q |-> (to_q && $past(sleep)));
   // R4: flag rises only with a device reset that restores the run key
   p_wrf_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrf_q) |-> (dev_rst_q && key_q == KEY_RUN));
   // R5: flag falls only after a status write with bit 0 clear
   p_wrf_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wrf_q) |-> $past(wr_stat && !wr_data[0]));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int MIN_LOG2    = 8,
   parameter int ILL_DELAY   = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit RD_SYNC     = 1'b1
) (
   input  logic             bus_clk,
   input  logic             slow_clk,
   input  logic             por_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   output logic             wr_busy,
   input  logic             rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic             wdt_clr,
   input  logic             sleep_mode,
   output logic             dev_rst,
   output logic             pcsp_rst,
   output logic             to_flag,
   output logic             wrf_flag
);

   localparam int REQ_W = $bits(wr_req_t);

   wr_req_t          req_in;
   wr_req_t          req_out;
   logic [REQ_W-1:0] req_out_bits;
   logic             wr_pulse;
   logic             clr_want;
   logic             clr_busy;
   logic             clr_go;
   logic             clr_pulse;
   logic [0:0]       clr_dummy;
   logic             sleep_s;
   logic [REG_W-1:0] ctrl_slow;
   logic [REG_W-1:0] stat_slow;
   logic [REG_W-1:0] ctrl_bus;
   logic [REG_W-1:0] stat_bus;

   assign req_in.addr = wr_addr;
   assign req_in.data = wr_data;

   wdt_xfer #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_wr_xfer (
      .src_clk    (bus_clk),
      .dst_clk    (slow_clk),
      .rst_n      (por_n),
      .src_launch (wr_en),
      .src_data   (req_in),
      .src_busy   (wr_busy),
      .dst_pulse  (wr_pulse),
      .dst_data   (req_out_bits)
   );
   assign req_out = req_out_bits;

   // clear requests wait here until the handshake can take them
   always_ff @(posedge bus_clk or negedge por_n) begin
      if (!por_n)       clr_want <= 1'b0;
      else if (wdt_clr) clr_want <= 1'b1;
      else if (clr_go)  clr_want <= 1'b0;
   end
   assign clr_go = clr_want && !clr_busy;

   wdt_xfer #(.W(1), .STAGES(SYNC_STAGES)) u_clr_xfer (
      .src_clk    (bus_clk),
      .dst_clk    (slow_clk),
      .rst_n      (por_n),
      .src_launch (clr_go),
      .src_data   (1'b1),
      .src_busy   (clr_busy),
      .dst_pulse  (clr_pulse),
      .dst_data   (clr_dummy)
   );

   wdt_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
      .clk   (slow_clk),
      .rst_n (por_n),
      .d     (sleep_mode),
      .q     (sleep_s)
   );

   wdt_core #(.MIN_LOG2(MIN_LOG2), .ILL_DELAY(ILL_DELAY)) u_core (
      .clk       (slow_clk),
      .rst_n     (por_n),
      .wr_pulse  (wr_pulse),
      .wr_addr   (req_out.addr),
      .wr_data   (req_out.data),
      .clr_pulse (clr_pulse),
      .sleep     (sleep_s),
      .dev_rst   (dev_rst),
      .pcsp_rst  (pcsp_rst),
      .to_flag   (to_flag),
      .wrf_flag  (wrf_flag),
      .ctrl_rd   (ctrl_slow),
      .stat_rd   (stat_slow)
   );

   if (RD_SYNC) begin : g_rd_sync
      wdt_sync #(.W(REG_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
         .clk   (bus_clk),
         .rst_n (por_n),
         .d     (ctrl_slow),
         .q     (ctrl_bus)
      );
      wdt_sync #(.W(REG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_stat_sync (
         .clk   (bus_clk),
         .rst_n (por_n),
         .d     (stat_slow),
         .q     (stat_bus)
      );
   end else begin : g_rd_direct
      assign ctrl_bus = ctrl_slow;
      assign stat_bus = stat_slow;
   end

   assign rd_data = (rd_addr == ADDR_CTRL) ? ctrl_bus : stat_bus;

   // R11: unimplemented status bits never read as 1
   p_stat_zero_r11: assert property (@(posedge bus_clk) disable iff (!por_n)
      stat_bus[REG_W-1:2] == '0);

endmodule

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/100ps
module keyed_wdt_bench;

   logic       bus_clk = 1'b0;
   logic       slow_clk = 1'b0;
   logic       por_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_busy;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       wdt_clr = 1'b0;
   logic       sleep_mode = 1'b0;
   logic       dev_rst;
   logic       pcsp_rst;
   logic       to_flag;
   logic       wrf_flag;

   int checks = 0;
   int errors = 0;
   int slow_cyc = 0;
   int n_dev = 0;
   int n_pcsp = 0;
   int pq[$];
   int dq[$];
   logic dev_d = 1'b0;
   logic pcsp_d = 1'b0;
   logic done = 1'b0;

   always #5 bus_clk = ~bus_clk;
   always #15.3 slow_clk = ~slow_clk;

   keyed_wdt u_keyed_wdt (
      .bus_clk    (bus_clk),
      .slow_clk   (slow_clk),
      .por_n      (por_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_busy    (wr_busy),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .wdt_clr    (wdt_clr),
      .sleep_mode (sleep_mode),
      .dev_rst    (dev_rst),
      .pcsp_rst   (pcsp_rst),
      .to_flag    (to_flag),
      .wrf_flag   (wrf_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // pulse model on every slow cycle: record times, check width and exclusivity
   always @(negedge slow_clk) begin
      slow_cyc++;
      if (por_n) begin
         if (dev_rst) begin dq.push_back(slow_cyc); n_dev++; end
         if (pcsp_rst) begin pq.push_back(slow_cyc); n_pcsp++; end
         if (dev_rst || pcsp_rst)
            chk(!(dev_rst && pcsp_rst) && !(dev_rst && dev_d) && !(pcsp_rst && pcsp_d),
                "R10 pulse shape", {dev_d, pcsp_d, dev_rst, pcsp_rst}, {2'b00, dev_rst, pcsp_rst});
      end
      dev_d  = dev_rst;
      pcsp_d = pcsp_rst;
   end

   task automatic wait_slow(input int n);
      repeat (n) @(negedge slow_clk);
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge bus_clk);
      while (wr_busy) @(negedge bus_clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] v);
      @(negedge bus_clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic clear_pulse();
      @(negedge bus_clk);
      wdt_clr = 1'b1;
      @(negedge bus_clk);
      wdt_clr = 1'b0;
   endtask

   task automatic wait_pcsp(input int n, input int guard);
      int g = 0;
      while (pq.size() < n && g < guard) begin @(negedge slow_clk); g++; end
   endtask

   task automatic wait_dev(input int n, input int guard);
      int g = 0;
      while (n_dev < n && g < guard) begin @(negedge slow_clk); g++; end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge bus_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      int base, t0, per;
      repeat (4) @(negedge bus_clk);
      por_n = 1'b1;
      wait_slow(10);

      // R1: power-on state
      bus_read(1'b0, v);
      chk(v == 8'hEA, "R1 ctrl reset", v, 8'hEA);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R1 status reset", v, 8'h00);
      chk(n_dev == 0 && n_pcsp == 0 && !wr_busy, "R1 no reset pulses", n_dev + n_pcsp, 0);

      // R3/R9/R7: sleep mode, sel 0 -> period 256, partial resets only
      sleep_mode = 1'b1;
      wait_slow(5);
      bus_write(1'b0, 8'h0A);
      pq.delete();
      wait_pcsp(3, 2000);
      per = (pq.size() >= 3) ? pq[2] - pq[1] : -1;
      chk(per == 256, "R3 enabled count overflows", per, 256);
      chk(per == 256, "R9 sel0 period", per, 256);
      chk(to_flag == 1'b1, "R7 sleep time-out sets TO", to_flag, 1);
      chk(n_dev == 0, "R7 no device reset in sleep", n_dev, 0);

      // R9: sel 1 -> period 512
      bus_write(1'b0, 8'h2A);
      pq.delete();
      wait_pcsp(3, 3000);
      per = (pq.size() >= 3) ? pq[2] - pq[1] : -1;
      chk(per == 512, "R9 sel1 period", per, 512);

      // R8: clear strobe clears TO and holds off overflow
      pq.delete();
      wait_pcsp(1, 1000);
      clear_pulse();
      wait_slow(20);
      chk(to_flag == 1'b0, "R8 clear drops TO", to_flag, 0);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R11 status upper bits zero", v, 8'h00);
      base = n_pcsp;
      for (int i = 0; i < 10; i++) begin
         clear_pulse();
         wait_slow(200);
      end
      chk(n_pcsp == base, "R8 repeated clears prevent overflow", n_pcsp, base);

      // R2: disable key
      bus_write(1'b0, 8'h15);
      wait_slow(20);
      base = n_pcsp;
      wait_slow(700);
      chk(n_pcsp == base && n_dev == 0, "R2 disabled no time-out", n_pcsp - base + n_dev, 0);
      bus_read(1'b0, v);
      chk(v == 8'h15, "R11 ctrl readback", v, 8'h15);

      // R12: write offered while busy is dropped
      @(negedge bus_clk);
      while (wr_busy) @(negedge bus_clk);
      wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h0A;
      @(negedge bus_clk);
      chk(wr_busy == 1'b1, "R12 busy after accept", wr_busy, 1);
      wr_data = 8'h03;
      @(negedge bus_clk);
      wr_en = 1'b0;
      base = n_dev;
      wait_slow(60);
      chk(n_dev == base, "R12 busy write ignored", n_dev, base);
      bus_read(1'b0, v);
      chk(v == 8'h0A, "R12 ctrl holds first write", v, 8'h0A);

      // R4: illegal key -> delayed device reset, WRF set, defaults restored
      base = n_dev;
      t0 = slow_cyc;
      bus_write(1'b0, 8'h03);
      wait_dev(base + 1, 60);
      t0 = (dq.size() > 0) ? dq[dq.size()-1] - t0 : 999;
      chk(n_dev == base + 1 && t0 >= 3 && t0 <= 20, "R4 delayed device reset", t0, 6);
      wait_slow(2);
      chk(wrf_flag == 1'b1, "R4 WRF set", wrf_flag, 1);
      wait_slow(10);
      bus_read(1'b0, v);
      chk(v == 8'hEA, "R4 ctrl restored", v, 8'hEA);

      // R5: WRF only cleared by writing 0
      bus_write(1'b1, 8'hFF);
      wait_slow(20);
      chk(wrf_flag == 1'b1, "R5 writing 1 keeps WRF", wrf_flag, 1);
      bus_write(1'b1, 8'h00);
      wait_slow(20);
      chk(wrf_flag == 1'b0, "R5 writing 0 clears WRF", wrf_flag, 0);
      bus_read(1'b1, v);
      chk(v[0] == 1'b0 && v[7:2] == 6'd0, "R5 status readback", v, {v[7:2], 1'b0, 1'b0} & 8'h02);

      // R6: run-mode overflow -> device reset, TO set, no partial reset
      sleep_mode = 1'b0;
      wait_slow(5);
      base = n_dev;
      t0 = n_pcsp;
      bus_write(1'b0, 8'h0A);
      wait_dev(base + 1, 600);
      wait_slow(2);
      chk(n_dev == base + 1, "R6 run overflow device reset", n_dev, base + 1);
      chk(n_pcsp == t0, "R6 no partial reset", n_pcsp, t0);
      chk(to_flag == 1'b1, "R6 TO set", to_flag, 1);
      chk(wrf_flag == 1'b0, "R5 WRF untouched by time-out", wrf_flag, 0);
      wait_slow(10);
      bus_read(1'b0, v);
      chk(v == 8'hEA, "R6 ctrl restored", v, 8'hEA);

      done = 1'b1;
      finish_run();
   end

endmodule